// File: doc/BRIEF.md
# Real-Time Clock Register Port

This block is the host-facing register file of a PC-style real-time clock. It holds 128 bytes behind a two-address access scheme. A write to the index address (`bus_sel` low) selects a byte. A read or write at the data address (`bus_sel` high) then reaches that byte. Most bytes are plain storage. The four clock control bytes at indices 0x0A to 0x0D have their own rules: a read-only update-busy bit, a hold bit that masks and clears other state, event flags that clear on read, and a constant status byte.

A 16-bit additive checksum covers the configuration bytes 0x10..0x2D. It is kept current by a background scan. Any write into that range restarts the scan. Timekeeping and rate generation sit outside the block. They send in event pulses and update-busy set/clear strobes. They receive the rate and mode control bytes and a load pulse whenever software has written a time field that should be taken over.

Top module: `rtc_cmos_port`

## Requirements
- R1: A write with `bus_sel` low stores `bus_wdata[6:0]` as the index; bit 7 is dropped. A read with `bus_sel` low returns 0xFF.
- R2: A read with `bus_sel` high raises `rd_valid` for one cycle in the next cycle, with the selected byte on `bus_rdata`. Plain bytes read back what was last written.
- R3: After reset, the rate byte (0x0A) is 0x26, the mode byte (0x0B) is 0x02, the flag byte (0x0C) is 0x00 and the status byte (0x0D) is 0x80. Plain bytes and both checksum bytes are 0x00, and `irq` is low.
- R4: Bit 7 of the rate byte (update-busy) is unaffected by writes to 0x0A. `upd_on` sets it when mode bit 7 (hold) is clear. `upd_off` clears it.
- R5: Writing the mode byte with bit 7 set stores bit 4 (update-end enable) as 0 and clears update-busy.
- R6: Writes to the flag byte 0x0C and the status byte 0x0D have no effect.
- R7: Reading 0x0C returns its value. The byte then becomes 0x00, and `irq` is low in the next cycle.
- R8: `evt_in[2]`, `evt_in[1]` and `evt_in[0]` set flag bits 6, 5 and 4. Flag bit 7 and `irq` are set when an event arrives whose enable (mode bit 6, 5 or 4 respectively) is set. An event that arrives in the same cycle as a read of 0x0C is kept.
- R9: The checksum is the 16-bit sum of bytes 0x10..0x2D, with the high byte at 0x2E and the low byte at 0x2F. A write into 0x10..0x2D holds `csum_busy` high for 30 cycles starting the next cycle, and a further write restarts that window.
- R10: A read of 0x2E or 0x2F while `csum_busy` is high is held. Its `rd_valid` comes one cycle after `csum_busy` falls and carries the new sum.
- R11: A write to 0x2E or 0x2F while no scan runs replaces that byte. During a scan such a write is dropped.
- R12: `tm_load` pulses in the cycle after a write to a time field (0x00, 0x02, 0x04, 0x06, 0x07, 0x08, 0x09) while hold is clear. It also pulses after a mode write that clears hold when hold was set. No pulse comes from a time-field write while hold is set.
- R13: `rate_ctrl` and `mode_ctrl` always show the current rate and mode bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects the index address, 1 the data address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, never together with `bus_wr` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data ready |
| evt_in | input | 3 | Event pulses: periodic, alarm, update-end |
| upd_on | input | 1 | Set update-busy |
| upd_off | input | 1 | Clear update-busy |
| irq | output | 1 | Level interrupt, equal to flag bit 7 |
| rate_ctrl | output | 8 | Current rate byte |
| mode_ctrl | output | 8 | Current mode byte |
| tm_load | output | 1 | One-cycle pulse to reload the time counter |
| csum_busy | output | 1 | Checksum scan running |

## Verification
Every register result shows up exactly one clock edge after the stimulus that caused it. Read data, flags, `irq`, `tm_load` and the control bytes are therefore due in the cycle after their strobe. `csum_busy` rises one cycle after a range write and stays high for 30 cycles. A held checksum read answers one cycle after that. The bench drives on falling edges and steps a behavioural model on each rising edge. It compares all outputs at the next falling edge, so each expected value is checked in the exact cycle it is due. Directed checks also count the busy window and the wait of a held read.

// File: rtl/rtc_cmos_pkg.sv
package rtc_cmos_pkg;

    localparam int IDX_W  = 7;
    localparam int BYTE_W = 8;
    localparam int NBYTES = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IX_RATE = 7'h0A;
    localparam logic [IDX_W-1:0] IX_MODE = 7'h0B;
    localparam logic [IDX_W-1:0] IX_FLAG = 7'h0C;
    localparam logic [IDX_W-1:0] IX_STAT = 7'h0D;

    localparam int SUM_FIRST = 16;
    localparam int SUM_LAST  = 45;
    localparam int SUM_HI_AT = 46;
    localparam int SUM_LO_AT = 47;

    localparam logic [BYTE_W-1:0] RATE_RST = 8'h26;
    localparam logic [BYTE_W-1:0] MODE_RST = 8'h02;
    localparam logic [BYTE_W-1:0] STAT_VAL = 8'h80;

    localparam int BUSY_BIT = 7;
    localparam int HOLD_BIT = 7;
    localparam int UEI_BIT  = 4;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] rate;
        logic [BYTE_W-1:0] mode;
        logic [BYTE_W-1:0] flag;
        logic [BYTE_W-1:0] rdata;
        logic              rvalid;
        logic              pend;
        logic              pend_lo;
        logic              load;
    } port_st_t;

    function automatic logic is_time_field(input logic [IDX_W-1:0] ix);
        return (ix == 7'h00) || (ix == 7'h02) || (ix == 7'h04) ||
               (ix == 7'h06) || (ix == 7'h07) || (ix == 7'h08) || (ix == 7'h09);
    endfunction

endpackage

// File: rtl/rtc_cmos_store.sv
module rtc_cmos_store #(
    parameter int IDX_W  = 7,
    parameter int BYTE_W = 8,
    localparam int NB    = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [BYTE_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [BYTE_W-1:0] rdata_b
);

    logic [NB*BYTE_W-1:0] flat;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '0;
            else if (we && waddr == IDX_W'(i))
                byte_q <= wdata;
        end
        assign flat[i*BYTE_W +: BYTE_W] = byte_q;
    end

    assign rdata_a = flat[32'(raddr_a) * BYTE_W +: BYTE_W];
    assign rdata_b = flat[32'(raddr_b) * BYTE_W +: BYTE_W];

endmodule

// File: rtl/rtc_cmos_csum.sv
module rtc_cmos_csum #(
    parameter int IDX_W  = 7,
    parameter int BYTE_W = 8,
    parameter int FIRST  = 16,
    parameter int LAST   = 45,
    localparam int SUM_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic [BYTE_W-1:0] load_data,
    output logic [IDX_W-1:0]  scan_ptr,
    input  logic [BYTE_W-1:0] scan_byte,
    output logic              busy,
    output logic [SUM_W-1:0]  sum
);

    localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(FIRST);
    localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(LAST);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] ptr;
        logic [SUM_W-1:0] acc;
        logic [SUM_W-1:0] sum;
    } scan_st_t;

    scan_st_t st_d, st_q;
    logic [SUM_W-1:0] add_v;

    always_comb begin
        st_d  = st_q;
        add_v = st_q.acc + {{BYTE_W{1'b0}}, scan_byte};
        if (st_q.busy) begin
            if (st_q.ptr == LAST_I) begin
                st_d.sum  = add_v;
                st_d.busy = 1'b0;
            end else begin
                st_d.acc = add_v;
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end else begin
            if (load_hi) st_d.sum[SUM_W-1:BYTE_W] = load_data;
            if (load_lo) st_d.sum[BYTE_W-1:0]     = load_data;
        end
        if (start) begin
            st_d.busy = 1'b1;
            st_d.ptr  = FIRST_I;
            st_d.acc  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.ptr  <= FIRST_I;
            st_q.acc  <= '0;
            st_q.sum  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_ptr = st_q.ptr;
    assign busy     = st_q.busy;
    assign sum      = st_q.sum;

endmodule

// File: rtl/rtc_cmos_port.sv
module rtc_cmos_port
    import rtc_cmos_pkg::*;
#(
    parameter int SUM_FIRST_P = SUM_FIRST,
    parameter int SUM_LAST_P  = SUM_LAST,
    parameter int SUM_HI_P    = SUM_HI_AT,
    parameter int SUM_LO_P    = SUM_LO_AT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              rd_valid,
    input  logic [2:0]        evt_in,
    input  logic              upd_on,
    input  logic              upd_off,
    output logic              irq,
    output logic [BYTE_W-1:0] rate_ctrl,
    output logic [BYTE_W-1:0] mode_ctrl,
    output logic              tm_load,
    output logic              csum_busy
);

    localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(SUM_FIRST_P);
    localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(SUM_LAST_P);
    localparam logic [IDX_W-1:0] HI_I    = IDX_W'(SUM_HI_P);
    localparam logic [IDX_W-1:0] LO_I    = IDX_W'(SUM_LO_P);

    port_st_t st_d, st_q;

    logic              wr_ix, wr_dat, rd_ix, rd_dat;
    logic              is_ctrl, is_sum, in_range;
    logic              store_we, scan_start, ld_hi, ld_lo;
    logic [IDX_W-1:0]  scan_ptr;
    logic [BYTE_W-1:0] store_rd, scan_byte, rd_val, flag_base, flag_new;
    logic [2*BYTE_W-1:0] sum_w;
    logic              busy_w, upd_bit;

    rtc_cmos_store #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (store_we),
        .waddr   (st_q.idx),
        .wdata   (bus_wdata),
        .raddr_a (st_q.idx),
        .rdata_a (store_rd),
        .raddr_b (scan_ptr),
        .rdata_b (scan_byte)
    );

    rtc_cmos_csum #(.IDX_W(IDX_W), .BYTE_W(BYTE_W),
                    .FIRST(SUM_FIRST_P), .LAST(SUM_LAST_P)) u_csum (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (scan_start),
        .load_hi   (ld_hi),
        .load_lo   (ld_lo),
        .load_data (bus_wdata),
        .scan_ptr  (scan_ptr),
        .scan_byte (scan_byte),
        .busy      (busy_w),
        .sum       (sum_w)
    );

    always_comb begin
        wr_ix    = bus_wr && !bus_sel;
        wr_dat   = bus_wr &&  bus_sel;
        rd_ix    = bus_rd && !bus_sel;
        rd_dat   = bus_rd &&  bus_sel;
        is_ctrl  = (st_q.idx == IX_RATE) || (st_q.idx == IX_MODE) ||
                   (st_q.idx == IX_FLAG) || (st_q.idx == IX_STAT);
        is_sum   = (st_q.idx == HI_I) || (st_q.idx == LO_I);
        in_range = (st_q.idx >= FIRST_I) && (st_q.idx <= LAST_I);

        store_we   = wr_dat && !is_ctrl && !is_sum;
        scan_start = wr_dat && in_range;
        ld_hi      = wr_dat && (st_q.idx == HI_I);
        ld_lo      = wr_dat && (st_q.idx == LO_I);

        if (st_q.idx == IX_RATE)      rd_val = st_q.rate;
        else if (st_q.idx == IX_MODE) rd_val = st_q.mode;
        else if (st_q.idx == IX_FLAG) rd_val = st_q.flag;
        else if (st_q.idx == IX_STAT) rd_val = STAT_VAL;
        else if (st_q.idx == HI_I)    rd_val = sum_w[2*BYTE_W-1:BYTE_W];
        else if (st_q.idx == LO_I)    rd_val = sum_w[BYTE_W-1:0];
        else                          rd_val = store_rd;

        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.load   = 1'b0;

        if (wr_ix)
            st_d.idx = bus_wdata[IDX_W-1:0];

        if (wr_dat) begin
            if (is_time_field(st_q.idx) && !st_q.mode[HOLD_BIT])
                st_d.load = 1'b1;
            if (st_q.idx == IX_RATE)
                st_d.rate = {st_q.rate[BUSY_BIT], bus_wdata[BUSY_BIT-1:0]};
            if (st_q.idx == IX_MODE) begin
                st_d.mode = bus_wdata;
                if (bus_wdata[HOLD_BIT])
                    st_d.mode[UEI_BIT] = 1'b0;
                else if (st_q.mode[HOLD_BIT])
                    st_d.load = 1'b1;
            end
        end

        upd_bit = st_d.rate[BUSY_BIT];
        if (upd_on && !st_q.mode[HOLD_BIT]) upd_bit = 1'b1;
        if (upd_off)                        upd_bit = 1'b0;
        if (wr_dat && st_q.idx == IX_MODE && bus_wdata[HOLD_BIT])
            upd_bit = 1'b0;
        st_d.rate[BUSY_BIT] = upd_bit;

        flag_base = (rd_dat && st_q.idx == IX_FLAG) ? '0 : st_q.flag;
        flag_new  = {|(evt_in & st_q.mode[6:4]), evt_in, 4'b0000};
        st_d.flag = flag_base | flag_new;

        if (st_q.pend && !busy_w) begin
            st_d.rdata  = st_q.pend_lo ? sum_w[BYTE_W-1:0] : sum_w[2*BYTE_W-1:BYTE_W];
            st_d.rvalid = 1'b1;
            st_d.pend   = 1'b0;
        end
        if (rd_ix) begin
            st_d.rdata  = '1;
            st_d.rvalid = 1'b1;
        end
        if (rd_dat) begin
            if (is_sum && busy_w) begin
                st_d.pend    = 1'b1;
                st_d.pend_lo = (st_q.idx == LO_I);
            end else begin
                st_d.rdata  = rd_val;
                st_d.rvalid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx     <= '0;
            st_q.rate    <= RATE_RST;
            st_q.mode    <= MODE_RST;
            st_q.flag    <= '0;
            st_q.rdata   <= '0;
            st_q.rvalid  <= 1'b0;
            st_q.pend    <= 1'b0;
            st_q.pend_lo <= 1'b0;
            st_q.load    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign rd_valid  = st_q.rvalid;
    assign irq       = st_q.flag[7];
    assign rate_ctrl = st_q.rate;
    assign mode_ctrl = st_q.mode;
    assign tm_load   = st_q.load;
    assign csum_busy = busy_w;

endmodule

// File: rtl/rtc_cmos_port_chk.sv
module rtc_cmos_port_chk
    import rtc_cmos_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              rd_valid,
    input logic [2:0]        evt_in,
    input logic              upd_on,
    input logic              upd_off,
    input logic              irq,
    input logic [BYTE_W-1:0] rate_ctrl,
    input logic [BYTE_W-1:0] mode_ctrl,
    input logic              tm_load,
    input logic              csum_busy,
    input logic [IDX_W-1:0]  idx
);

    // R1: an index-address read answers 0xFF in the next cycle
    p_idx_read_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_sel) |=> (rd_valid && bus_rdata == 8'hFF));

    // R4: a write to the rate byte keeps the update-busy bit
    p_busy_bit_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && idx == IX_RATE && !upd_on && !upd_off)
        |=> rate_ctrl[BUSY_BIT] == $past(rate_ctrl[BUSY_BIT]));

    // R5: setting hold clears update-end enable and update-busy
    p_hold_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && idx == IX_MODE && bus_wdata[HOLD_BIT])
        |=> (!mode_ctrl[UEI_BIT] && !rate_ctrl[BUSY_BIT]));

    // R6: the status byte always reads 0x80
    p_status_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel && idx == IX_STAT) |=> bus_rdata == STAT_VAL);

    // R7: reading the flag byte with no new event drops irq
    p_flag_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel && idx == IX_FLAG && evt_in == 3'b000) |=> !irq);

    // R8: irq rises only on an enabled event
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(evt_in & mode_ctrl[6:4])));

    // R9: a write into the summed range starts a scan
    p_scan_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && idx >= 7'(SUM_FIRST) && idx <= 7'(SUM_LAST))
        |=> csum_busy);

    // R12: a load pulse always follows a data write
    p_load_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tm_load |-> $past(bus_wr && bus_sel));

endmodule

bind rtc_cmos_port rtc_cmos_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rd_valid  (rd_valid),
    .evt_in    (evt_in),
    .upd_on    (upd_on),
    .upd_off   (upd_off),
    .irq       (irq),
    .rate_ctrl (rate_ctrl),
    .mode_ctrl (mode_ctrl),
    .tm_load   (tm_load),
    .csum_busy (csum_busy),
    .idx       (st_q.idx)
);

// File: tb/rtc_cmos_port_tb.sv
module rtc_cmos_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SCAN_LEN   = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rd_valid;
    logic [2:0] evt_in = 3'b000;
    logic       upd_on = 1'b0, upd_off = 1'b0;
    logic       irq, tm_load, csum_busy;
    logic [7:0] rate_ctrl, mode_ctrl;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic model_on = 1'b0;
    logic last_load;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_cmos_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_valid(rd_valid),
        .evt_in(evt_in), .upd_on(upd_on), .upd_off(upd_off), .irq(irq),
        .rate_ctrl(rate_ctrl), .mode_ctrl(mode_ctrl), .tm_load(tm_load),
        .csum_busy(csum_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_mem [128];
    int m_idx, m_a, m_b, m_c, m_sum, m_busy, m_rd;
    bit m_rv, m_pend, m_pend_lo, m_load;

    function automatic int m_value(input int ix);
        if (ix == 10) return m_a;
        if (ix == 11) return m_b;
        if (ix == 12) return m_c;
        if (ix == 13) return 8'h80;
        if (ix == 46) return (m_sum >> 8) & 8'hFF;
        if (ix == 47) return m_sum & 8'hFF;
        return m_mem[ix];
    endfunction

    function automatic bit m_time(input int ix);
        return ix == 0 || ix == 2 || ix == 4 || ix == 6 || ix == 7 || ix == 8 || ix == 9;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_idx = 0; m_a = 8'h26; m_b = 8'h02; m_c = 0; m_sum = 0; m_busy = 0;
            m_rd = 0; m_rv = 0; m_pend = 0; m_pend_lo = 0; m_load = 0;
        end else begin
            bit was_busy, clr_c, new_busy;
            int ob, w;
            was_busy = (m_busy > 0);
            ob = m_b;
            w = bus_wdata;
            m_rv = 0; m_load = 0; clr_c = 0;
            if (m_pend && !was_busy) begin
                m_rd = m_pend_lo ? (m_sum & 8'hFF) : ((m_sum >> 8) & 8'hFF);
                m_rv = 1; m_pend = 0;
            end
            if (bus_rd && !bus_sel) begin m_rd = 8'hFF; m_rv = 1; end
            if (bus_rd && bus_sel) begin
                if ((m_idx == 46 || m_idx == 47) && was_busy) begin
                    m_pend = 1; m_pend_lo = (m_idx == 47);
                end else begin
                    m_rd = m_value(m_idx); m_rv = 1;
                end
                if (m_idx == 12) clr_c = 1;
            end
            if (was_busy) begin
                m_busy--;
                if (m_busy == 0) begin
                    m_sum = 0;
                    for (int k = 16; k <= 45; k++) m_sum += m_mem[k];
                    m_sum &= 16'hFFFF;
                end
            end
            new_busy = 0;
            if (bus_wr && !bus_sel) m_idx = w & 8'h7F;
            else if (bus_wr && bus_sel) begin
                if (m_idx == 10) m_a = (w & 8'h7F) | (m_a & 8'h80);
                else if (m_idx == 11) begin
                    if (w & 8'h80) m_b = w & 8'hEF;
                    else begin
                        if (ob & 8'h80) m_load = 1;
                        m_b = w;
                    end
                end else if (m_idx == 12 || m_idx == 13) begin
                end else if (m_idx == 46) begin
                    if (!was_busy) m_sum = (m_sum & 8'hFF) | (w << 8);
                end else if (m_idx == 47) begin
                    if (!was_busy) m_sum = (m_sum & 16'hFF00) | w;
                end else begin
                    m_mem[m_idx] = w;
                    if (m_time(m_idx) && !(ob & 8'h80)) m_load = 1;
                    if (m_idx >= 16 && m_idx <= 45) new_busy = 1;
                end
            end
            if (new_busy) m_busy = SCAN_LEN;
            if (upd_on && !(ob & 8'h80)) m_a |= 8'h80;
            if (upd_off) m_a &= 8'h7F;
            if (bus_wr && bus_sel && m_idx == 11 && (w & 8'h80)) m_a &= 8'h7F;
            m_c = (clr_c ? 0 : m_c) | (evt_in << 4) | (((evt_in & (ob >> 4)) != 0) ? 8'h80 : 0);
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            chk("R2 rd_valid", rd_valid, m_rv);
            if (m_rv) chk("R2 bus_rdata", bus_rdata, m_rd);
            chk("R4 rate_ctrl", rate_ctrl, m_a);
            chk("R5 mode_ctrl", mode_ctrl, m_b);
            chk("R8 irq", irq, (m_c >> 7) & 1);
            chk("R12 tm_load", tm_load, m_load);
            chk("R9 csum_busy", csum_busy, m_busy > 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr_idx(input logic [7:0] v);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        last_load = tm_load;
    endtask

    task automatic poke(input logic [7:0] ix, input logic [7:0] v);
        wr_idx(ix);
        wr_dat(v);
    endtask

    task automatic rd_now(input logic [7:0] exp, input string tag, output int waited);
        bus_sel = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        waited = 0;
        while (!rd_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk(tag, bus_rdata, exp);
    endtask

    task automatic peek(input logic [7:0] ix, input logic [7:0] exp, input string tag);
        int w;
        wr_idx(ix);
        rd_now(exp, tag, w);
    endtask

    task automatic pulse_evt(input logic [2:0] v);
        evt_in = v;
        @(negedge clk);
        evt_in = 3'b000;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (csum_busy && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int w, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);

        // R3 reset state
        chk("R3 irq after reset", irq, 0);
        chk("R13 rate_ctrl after reset", rate_ctrl, 8'h26);
        chk("R13 mode_ctrl after reset", mode_ctrl, 8'h02);
        peek(8'h0A, 8'h26, "R3 rate byte");
        peek(8'h0B, 8'h02, "R3 mode byte");
        peek(8'h0C, 8'h00, "R3 flag byte");
        peek(8'h0D, 8'h80, "R3 status byte");
        peek(8'h20, 8'h00, "R3 plain byte");
        peek(8'h2E, 8'h00, "R3 checksum high");

        // R1 index bit 7 dropped, index read gives 0xFF
        poke(8'h8E, 8'h5A);
        peek(8'h0E, 8'h5A, "R1 index masked");
        bus_sel = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R1 index read", bus_rdata, 8'hFF);

        // R2 plain storage
        poke(8'h40, 8'h11);
        poke(8'h7F, 8'hEE);
        peek(8'h40, 8'h11, "R2 byte 0x40");
        peek(8'h7F, 8'hEE, "R2 byte 0x7F");

        // R6 flag and status ignore writes
        poke(8'h0C, 8'hFF);
        poke(8'h0D, 8'h00);
        peek(8'h0C, 8'h00, "R6 flag write ignored");
        peek(8'h0D, 8'h80, "R6 status write ignored");

        // R4 update-busy bit
        poke(8'h0A, 8'hFF);
        peek(8'h0A, 8'h7F, "R4 busy bit not writable");
        upd_on = 1'b1; @(negedge clk); upd_on = 1'b0;
        poke(8'h0A, 8'h26);
        peek(8'h0A, 8'hA6, "R4 busy bit kept over write");
        upd_off = 1'b1; @(negedge clk); upd_off = 1'b0;
        chk("R4 busy cleared", rate_ctrl, 8'h26);

        // R12 load pulse on time field write with hold clear
        poke(8'h00, 8'h30);
        chk("R12 load after time write", last_load, 1);

        // R5 hold bit
        upd_on = 1'b1; @(negedge clk); upd_on = 1'b0;
        poke(8'h0B, 8'h92);
        peek(8'h0B, 8'h82, "R5 update-end enable forced low");
        chk("R5 busy bit cleared", rate_ctrl, 8'h26);
        poke(8'h00, 8'h45);
        chk("R12 no load while hold", last_load, 0);
        upd_on = 1'b1; @(negedge clk); upd_on = 1'b0;
        chk("R4 busy set ignored under hold", rate_ctrl, 8'h26);
        poke(8'h0B, 8'h02);
        chk("R12 load on hold release", last_load, 1);
        poke(8'h0B, 8'h22);
        chk("R12 no load without prior hold", last_load, 0);
        chk("R13 mode_ctrl follows", mode_ctrl, 8'h22);

        // R8 and R7 events and clear on read
        pulse_evt(3'b010);
        chk("R8 irq on enabled alarm", irq, 1);
        peek(8'h0C, 8'hA0, "R7 flag read value");
        chk("R7 irq low after read", irq, 0);
        pulse_evt(3'b001);
        chk("R8 no irq when disabled", irq, 0);
        bus_sel = 1'b1; bus_rd = 1'b1; evt_in = 3'b100;
        @(negedge clk);
        bus_rd = 1'b0; evt_in = 3'b000;
        chk("R7 flag read before clear", bus_rdata, 8'h10);
        rd_now(8'h40, "R8 event kept through clear", w);
        rd_now(8'h00, "R7 flag cleared", w);

        // R9 checksum and busy window
        poke(8'h10, 8'h01);
        n = 0;
        while (csum_busy && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R9 busy window length", n, SCAN_LEN);
        poke(8'h2D, 8'hFF);
        poke(8'h20, 8'h80);
        wait_idle();
        peek(8'h2E, 8'h01, "R9 checksum high");
        peek(8'h2F, 8'h80, "R9 checksum low");

        // R10 held read during scan
        poke(8'h11, 8'h90);
        wr_idx(8'h2E);
        rd_now(8'h02, "R10 held read value", w);
        chk("R10 read was held", w > 0, 1);
        peek(8'h2F, 8'h10, "R10 low byte after scan");

        // R11 direct checksum writes
        poke(8'h2F, 8'h33);
        peek(8'h2F, 8'h33, "R11 direct write idle");
        poke(8'h12, 8'h00);
        wr_idx(8'h2E);
        wr_dat(8'h77);
        wait_idle();
        peek(8'h2E, 8'h02, "R11 write during scan dropped");
        peek(8'h2F, 8'h10, "R11 scan restores low byte");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule